// File: doc/BRIEF.md
# BCD Watchdog Timer with Reset/Interrupt Steering

This block is a software watchdog whose timeout is held as two binary-coded-decimal bytes. One byte holds hundredths of a second and the other holds whole seconds. Together they give timeouts from 00.01 s up to 99.99 s. A one-cycle tick input, nominally at 100 Hz, decrements the live count in BCD. When the count runs out, the block sets a sticky expiry flag. A steering bit then selects the consequence: either an active-low reset pulse of fixed length, or a level interrupt that stays up until software clears the flag.

Software reaches the block over a small register bus that has write, read and address strobes and a combinational read path. A write to either timeout byte reloads the live count from both programmed bytes and restarts the countdown; this is how the system kicks the watchdog. When both bytes are zero, the watchdog is stopped. After each expiry, the count reloads on its own, so an unserviced system is hit again after every full period.

Top module: `bcd_wdt`

## Requirements
- R1: After reset, all four registers read 0x00, the reset output wd_rst_no is high and irq_o is low.
- R2: Offset 0xC (hundredths) and offset 0xD (seconds) read back the byte last written. Offset 0xF reads enable in bit 1 and steering in bit 0, and its upper six bits read zero. Offset 0xE carries the expiry flag in bit 1 and zeros elsewhere.
- R3: With enable set and a nonzero programmed value of SS.HH (BCD), expiry occurs on exactly the (SS*100+HH)-th tick after the last reload. When the hundredths byte is 00, a decrement gives 99 and borrows one from the seconds byte.
- R4: Ticks have no effect while enable (offset 0xF bit 1) is clear. The live count is held and resumes when enable is set again.
- R5: Expiry sets the flag at offset 0xE bit 1. A read of offset 0xE returns the flag and clears it.
- R6: With steering (offset 0xF bit 0) set, an expiry drives wd_rst_no low for exactly RST_CYCLES clock cycles, starting two clock edges after the edge that samples the expiring tick, and irq_o stays low.
- R7: With steering clear, irq_o is high while the flag is set and enable is set. It first rises two edges after the edge that samples the expiring tick, and it falls once offset 0xE is read.
- R8: After an expiry, the live count reloads from the programmed bytes, so the next expiry comes a full period later without any software action.
- R9: Any write to offset 0xC or 0xD reloads the live count from both programmed bytes, discarding the progress of the count.
- R10: When both programmed bytes are zero, the watchdog stops: no tick produces an expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle countdown tick (100 Hz nominal) |
| bus_we_i | input | 1 | Register write strobe |
| bus_re_i | input | 1 | Register read strobe (clears the flag when reading 0xE) |
| bus_addr_i | input | ADDR_W | Register offset |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, combinational from the address |
| wd_rst_no | output | 1 | Active-low reset pulse on steered expiry |
| irq_o | output | 1 | Interrupt level on non-steered expiry |

## Verification
The hardest situation to reach is the borrow chain across decades of seconds, for example the step from 10.00 to 09.99. That decrement only happens after hundreds of ticks, and it is visible only through when the expiry comes. The stimulus programs 10.00 and also 01.02, then issues the full tick train. The bench's own decimal model predicts the exact cycle of the expiry event, so a wrong borrow shows up as a mistimed or missing event. Kicks in the middle of a count and disabled stretches are mixed in, so that the same prediction also covers reload and hold behaviour.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int BYTE_W = 8;

    localparam int OFS_HUND = 'hC;
    localparam int OFS_SEC  = 'hD;
    localparam int OFS_STAT = 'hE;
    localparam int OFS_CTRL = 'hF;

    localparam int CTRL_EN_BIT    = 1;
    localparam int CTRL_STEER_BIT = 0;
    localparam int STAT_FLAG_BIT  = 1;

    typedef struct packed {
        logic [BYTE_W-1:0] sec;
        logic [BYTE_W-1:0] hund;
    } bcd_time_t;

    function automatic logic [BYTE_W-1:0] bcd_byte_dec(input logic [BYTE_W-1:0] v);
        logic [BYTE_W-1:0] r;
        if (v[3:0] == 4'd0) begin
            r = {v[7:4] - 4'd1, 4'd9};
        end else begin
            r = {v[7:4], v[3:0] - 4'd1};
        end
        return r;
    endfunction

    function automatic bcd_time_t bcd_time_dec(input bcd_time_t t);
        bcd_time_t r;
        r = t;
        if (t.hund == '0) begin
            r.hund = 8'h99;
            r.sec  = bcd_byte_dec(t.sec);
        end else begin
            r.hund = bcd_byte_dec(t.hund);
        end
        return r;
    endfunction

    function automatic logic bcd_time_zero(input bcd_time_t t);
        return (t.hund == '0) && (t.sec == '0);
    endfunction

endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                we_i,
    input  logic                re_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [BYTE_W-1:0]   wdata_i,
    input  logic                expire_i,
    output bcd_time_t           prog_o,
    output logic                en_o,
    output logic                steer_o,
    output logic                flag_o,
    output logic                load_o,
    output logic [BYTE_W-1:0]   rdata_o
);

    localparam logic [ADDR_W-1:0] A_HUND = ADDR_W'(OFS_HUND);
    localparam logic [ADDR_W-1:0] A_SEC  = ADDR_W'(OFS_SEC);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);

    typedef struct packed {
        bcd_time_t prog;
        logic      en;
        logic      steer;
        logic      flag;
        logic      load;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.load = 1'b0;
        if (we_i) begin
            unique case (addr_i)
                A_HUND: begin
                    st_d.prog.hund = wdata_i;
                    st_d.load      = 1'b1;
                end
                A_SEC: begin
                    st_d.prog.sec = wdata_i;
                    st_d.load     = 1'b1;
                end
                A_CTRL: begin
                    st_d.en    = wdata_i[CTRL_EN_BIT];
                    st_d.steer = wdata_i[CTRL_STEER_BIT];
                end
                default: ;
            endcase
        end
        if (re_i && (addr_i == A_STAT)) begin
            st_d.flag = 1'b0;
        end
        // A new expiry outranks a clearing read in the same cycle.
        if (expire_i) begin
            st_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        unique case (addr_i)
            A_HUND: rdata_o = st_q.prog.hund;
            A_SEC:  rdata_o = st_q.prog.sec;
            A_STAT: rdata_o[STAT_FLAG_BIT] = st_q.flag;
            A_CTRL: begin
                rdata_o[CTRL_EN_BIT]    = st_q.en;
                rdata_o[CTRL_STEER_BIT] = st_q.steer;
            end
            default: ;
        endcase
    end

    assign prog_o  = st_q.prog;
    assign en_o    = st_q.en;
    assign steer_o = st_q.steer;
    assign flag_o  = st_q.flag;
    assign load_o  = st_q.load;

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
    import wdt_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_ni,
    input  logic      tick_i,
    input  logic      en_i,
    input  logic      load_i,
    input  bcd_time_t prog_i,
    output bcd_time_t cnt_o,
    output logic      running_o,
    output logic      expire_o
);

    typedef struct packed {
        bcd_time_t cnt;
        logic      run;
        logic      expire;
    } cnt_t;

    cnt_t st_d, st_q;
    bcd_time_t dec_w;

    always_comb begin
        dec_w       = bcd_time_dec(st_q.cnt);
        st_d        = st_q;
        st_d.expire = 1'b0;
        if (load_i) begin
            st_d.cnt = prog_i;
            st_d.run = !bcd_time_zero(prog_i);
        end else if (tick_i && en_i && st_q.run) begin
            if (bcd_time_zero(dec_w)) begin
                st_d.expire = 1'b1;
                st_d.cnt    = prog_i;
            end else begin
                st_d.cnt = dec_w;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o     = st_q.cnt;
    assign running_o = st_q.run;
    assign expire_o  = st_q.expire;

endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
    parameter int CYCLES = 8
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic fire_i,
    output logic pulse_no
);

    localparam int CW = $clog2(CYCLES + 1);

    typedef struct packed {
        logic [CW-1:0] left;
    } pulse_t;

    pulse_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (fire_i) begin
            st_d.left = CW'(CYCLES);
        end else if (st_q.left != '0) begin
            st_d.left = st_q.left - CW'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pulse_no = (st_q.left == '0);

endmodule

// File: rtl/bcd_wdt.sv
module bcd_wdt
    import wdt_pkg::*;
#(
    parameter int ADDR_W     = 4,
    parameter int RST_CYCLES = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic              bus_we_i,
    input  logic              bus_re_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [7:0]        bus_wdata_i,
    output logic [7:0]        bus_rdata_o,
    output logic              wd_rst_no,
    output logic              irq_o
);

    bcd_time_t prog_w;
    bcd_time_t cnt_w;
    logic      en_w;
    logic      steer_w;
    logic      flag_w;
    logic      load_w;
    logic      run_w;
    logic      expire_w;

    wdt_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .we_i     (bus_we_i),
        .re_i     (bus_re_i),
        .addr_i   (bus_addr_i),
        .wdata_i  (bus_wdata_i),
        .expire_i (expire_w),
        .prog_o   (prog_w),
        .en_o     (en_w),
        .steer_o  (steer_w),
        .flag_o   (flag_w),
        .load_o   (load_w),
        .rdata_o  (bus_rdata_o)
    );

    wdt_counter u_cnt (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .tick_i    (tick_i),
        .en_i      (en_w),
        .load_i    (load_w),
        .prog_i    (prog_w),
        .cnt_o     (cnt_w),
        .running_o (run_w),
        .expire_o  (expire_w)
    );

    wdt_pulse #(.CYCLES(RST_CYCLES)) u_pulse (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .fire_i   (expire_w && steer_w),
        .pulse_no (wd_rst_no)
    );

    assign irq_o = flag_w && en_w && !steer_w;

endmodule

// File: rtl/wdt_checker.sv
module wdt_checker
    import wdt_pkg::*;
#(
    parameter int ADDR_W     = 4,
    parameter int RST_CYCLES = 8
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              tick_i,
    input logic              re_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic              en_i,
    input logic              steer_i,
    input logic              load_i,
    input logic              running_i,
    input logic              expire_i,
    input logic              flag_i,
    input bcd_time_t         cnt_i,
    input logic              wd_rst_ni
);

    int low_run;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            low_run <= 0;
        end else if (!wd_rst_ni) begin
            low_run <= low_run + 1;
        end else begin
            low_run <= 0;
        end
    end

    // R5: the flag follows every expiry
    a_r5_flag_after_expire: assert property (@(posedge clk_i) disable iff (!rst_ni)
        expire_i |=> flag_i);

    // R5: a status read with no competing expiry clears the flag
    a_r5_read_clears_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (re_i && addr_i == ADDR_W'(OFS_STAT) && !expire_i) |=> !flag_i);

    // R3: an accepted tick always moves the count or expires
    a_r3_tick_moves_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && en_i && running_i && !load_i) |=> (expire_i || !$stable(cnt_i)));

    // R4: with enable clear, the count holds
    a_r4_hold_when_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!en_i && !load_i) |=> ($stable(cnt_i) && !expire_i));

    // R10: a stopped watchdog never expires
    a_r10_stopped_no_expire: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!running_i && !load_i) |=> !expire_i);

    // R6: a reset pulse only begins under steering
    a_r6_fall_needs_steer: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(wd_rst_ni) |-> $past(steer_i));

    // R6: the pulse never outlasts its length
    a_r6_pulse_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
        low_run <= RST_CYCLES);

endmodule

bind bcd_wdt wdt_checker #(.ADDR_W(ADDR_W), .RST_CYCLES(RST_CYCLES)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .re_i      (bus_re_i),
    .addr_i    (bus_addr_i),
    .en_i      (en_w),
    .steer_i   (steer_w),
    .load_i    (load_w),
    .running_i (run_w),
    .expire_i  (expire_w),
    .flag_i    (flag_w),
    .cnt_i     (cnt_w),
    .wd_rst_ni (wd_rst_no)
);

// File: tb/bcd_wdt_test.sv
`timescale 1ns/1ps
module bcd_wdt_test;

    localparam int ADDR_W = 4;
    localparam int RSTC   = 8;

    logic              clk = 1'b0;
    logic              rst_ni = 1'b0;
    logic              tick = 1'b0;
    logic              we = 1'b0;
    logic              re = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [7:0]        wdata = '0;
    logic [7:0]        rdata;
    logic              wd_rst_n;
    logic              irq;

    always #2 clk = ~clk;

    bcd_wdt #(.ADDR_W(ADDR_W), .RST_CYCLES(RSTC)) uut (
        .clk_i       (clk),
        .rst_ni      (rst_ni),
        .tick_i      (tick),
        .bus_we_i    (we),
        .bus_re_i    (re),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .wd_rst_no   (wd_rst_n),
        .irq_o       (irq)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    typedef struct {
        int at;
        bit is_rst;
    } ev_t;
    ev_t expq[$];

    // bench model
    logic [7:0] m_hund = 8'h00;
    logic [7:0] m_sec  = 8'h00;
    int m_reload = 0, m_left = 0;
    bit m_run = 0, m_en = 0, m_steer = 0, m_flag = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int bcd2int(input logic [7:0] b);
        return int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction

    task automatic wr(input int a, input logic [7:0] d);
        @(negedge clk);
        we = 1'b1; addr = ADDR_W'(a); wdata = d;
        @(negedge clk);
        we = 1'b0;
        @(negedge clk);
        if (a == 'hC || a == 'hD) begin
            if (a == 'hC) m_hund = d; else m_sec = d;
            m_reload = bcd2int(m_sec) * 100 + bcd2int(m_hund);
            m_left   = m_reload;
            m_run    = (m_reload != 0);
        end else if (a == 'hF) begin
            m_en    = d[1];
            m_steer = d[0];
        end
    endtask

    task automatic rd(input int a, output logic [7:0] d);
        @(negedge clk);
        re = 1'b1; addr = ADDR_W'(a);
        #1 d = rdata;
        @(negedge clk);
        re = 1'b0;
        if (a == 'hE) m_flag = 1'b0;
    endtask

    task automatic tick1();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        if (m_en && m_run) begin
            m_left--;
            if (m_left == 0) begin
                ev_t e;
                m_left = m_reload;
                e.at = cyc + 1;
                if (m_steer) begin
                    e.is_rst = 1'b1;
                    expq.push_back(e);
                end else if (!m_flag) begin
                    e.is_rst = 1'b0;
                    expq.push_back(e);
                end
                m_flag = 1'b1;
            end
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick1();
    endtask

    // monitor: pops expected events as the design produces them
    bit prev_rst = 1'b1, prev_irq = 1'b0;
    int fall_at = 0;
    always @(negedge clk) begin
        if (rst_ni) begin
            if (!wd_rst_n && prev_rst) begin
                fall_at = cyc;
                if (expq.size() == 0) begin
                    chk(1'b0, "R6", "unexpected reset pulse at cycle", cyc, -1);
                end else begin
                    ev_t e;
                    e = expq.pop_front();
                    chk(e.is_rst && e.at == cyc, "R3/R6", "reset pulse cycle", cyc, e.at);
                end
            end
            if (wd_rst_n && !prev_rst) begin
                chk(cyc - fall_at == RSTC, "R6", "reset pulse width", cyc - fall_at, RSTC);
            end
            if (irq && !prev_irq) begin
                if (expq.size() == 0) begin
                    chk(1'b0, "R7", "unexpected irq at cycle", cyc, -1);
                end else begin
                    ev_t e;
                    e = expq.pop_front();
                    chk(!e.is_rst && e.at == cyc, "R3/R7", "irq rise cycle", cyc, e.at);
                end
            end
            prev_rst = wd_rst_n;
            prev_irq = irq;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_ni = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(wd_rst_n == 1'b1, "R1", "wd_rst_no after reset", int'(wd_rst_n), 1);
        chk(irq == 1'b0, "R1", "irq after reset", int'(irq), 0);
        for (int a = 'hC; a <= 'hF; a++) begin
            rd(a, d);
            chk(d == 8'h00, "R1", "register after reset", int'(d), 0);
        end

        // R2 readback, R3/R7 short count with interrupt
        wr('hF, 8'h02);
        wr('hC, 8'h05);
        rd('hC, d);
        chk(d == 8'h05, "R2", "hundredths readback", int'(d), 5);
        rd('hF, d);
        chk(d == 8'h02, "R2", "control readback", int'(d), 2);
        ticks(5);
        @(negedge clk);
        chk(irq == 1'b1, "R7", "irq high after expiry", int'(irq), 1);
        rd('hE, d);
        chk(d == 8'h02, "R5", "status shows flag", int'(d), 2);
        chk(irq == 1'b0, "R7", "irq low after status read", int'(irq), 0);
        rd('hE, d);
        chk(d == 8'h00, "R5", "flag cleared by read", int'(d), 0);

        // R8 automatic reload
        ticks(5);
        @(negedge clk);
        chk(irq == 1'b1, "R8", "second expiry without reprogramming", int'(irq), 1);
        rd('hE, d);

        // R9 kick mid-count
        ticks(3);
        wr('hC, 8'h05);
        ticks(4);
        chk(irq == 1'b0, "R9", "no expiry before full period after kick", int'(irq), 0);
        ticks(1);
        @(negedge clk);
        chk(irq == 1'b1, "R9", "expiry a full period after kick", int'(irq), 1);
        rd('hE, d);

        // R3 borrow from seconds: 01.02 then 10.00
        wr('hD, 8'h01);
        wr('hC, 8'h02);
        rd('hD, d);
        chk(d == 8'h01, "R2", "seconds readback", int'(d), 1);
        ticks(101);
        chk(irq == 1'b0, "R3", "no expiry one tick early at 01.02", int'(irq), 0);
        ticks(1);
        @(negedge clk);
        chk(irq == 1'b1, "R3", "expiry at 102 ticks", int'(irq), 1);
        rd('hE, d);
        wr('hD, 8'h10);
        wr('hC, 8'h00);
        ticks(1000);
        @(negedge clk);
        chk(irq == 1'b1, "R3", "expiry at 1000 ticks for 10.00", int'(irq), 1);
        rd('hE, d);

        // R4 enable gating
        wr('hF, 8'h00);
        wr('hD, 8'h00);
        wr('hC, 8'h03);
        ticks(10);
        rd('hE, d);
        chk(d == 8'h00, "R4", "no flag while disabled", int'(d), 0);
        wr('hF, 8'h02);
        ticks(2);
        chk(irq == 1'b0, "R4", "count held while disabled", int'(irq), 0);
        ticks(1);
        @(negedge clk);
        chk(irq == 1'b1, "R4", "count resumes after enable", int'(irq), 1);
        rd('hE, d);

        // R6 steered reset pulse
        wr('hF, 8'h03);
        wr('hC, 8'h06);
        ticks(6);
        repeat (RSTC + 2) @(negedge clk);
        chk(irq == 1'b0, "R6", "irq stays low under steering", int'(irq), 0);
        rd('hE, d);
        chk(d == 8'h02, "R5", "flag set by steered expiry", int'(d), 2);
        ticks(6);
        repeat (RSTC + 2) @(negedge clk);
        wr('hF, 8'hFF);
        rd('hF, d);
        chk(d == 8'h03, "R2", "control upper bits read zero", int'(d), 3);
        rd('hE, d);

        // R10 both zero stops the watchdog
        wr('hC, 8'h00);
        ticks(20);
        chk(wd_rst_n == 1'b1, "R10", "no reset while stopped", int'(wd_rst_n), 1);
        rd('hE, d);
        chk(d == 8'h00, "R10", "no flag while stopped", int'(d), 0);

        repeat (RSTC + 4) @(negedge clk);
        chk(expq.size() == 0, "R3", "expected events left unseen", expq.size(), 0);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule